// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control and datapath core of a non-pipelined processor that runs a small eight-register, word-addressed instruction set: add, nand, lw, sw, beq, jalr, noop and halt. It steps through at most five phases, one per clock: fetch, decode, execute, memory and writeback. Each opcode takes only the phases it needs. The block holds the program counter, the instruction register and the operand, ALU-result and memory-data registers. It drives the read and write controls of an external instruction memory, register file and data memory. Those three storage elements sit outside the block and read combinationally.

Two free-running counters report total active cycles and retired instructions, so software or a testbench can derive CPI directly. After a halt the core parks in a terminal state until reset.

Top module: `mcyc_core`

## Requirements
- R1: Reset is synchronous and active high. It returns the core to the fetch phase with the PC at 0, both counters at 0 and `halted` low.
- R2: In the fetch phase the instruction at `imem_addr` (the PC) is captured. The PC advances by one through its own incrementer, not the ALU, so `imem_addr` reads PC+1 in the following cycle.
- R3: add and nand take four cycles (fetch, decode, execute, writeback). They write regA+regB or ~(regA & regB) to the register named by the dest field.
- R4: lw takes five cycles. It writes data memory word [regA + sign-extended offset] into regB, and its one data-memory read cycle raises `dmem_re`.
- R5: sw takes four cycles. It writes regB to data memory word [regA + sign-extended offset] and writes no register.
- R6: beq takes three cycles. When regA equals regB the next PC is PC+1+offset, with the offset sign-extended so backward branches work; otherwise it is PC+1.
- R7: jalr takes three cycles. It writes PC+1 into regB and continues at the value regA held before the write, including when regA and regB name the same register.
- R8: noop takes two cycles (fetch and decode) and writes neither the register file nor data memory.
- R9: halt takes two cycles and then holds the core in a terminal state until reset. In that state the PC, counters, register file and data memory all stay unchanged.
- R10: `cycle_count` rises by one in every cycle the core is not halted. `retired_count` rises by one for each completed instruction, halt included.
- R11: The instruction word is 25 bits: opcode [24:22] (add 0, nand 1, lw 2, sw 3, beq 4, jalr 5, halt 6, noop 7), regA [21:19], regB [18:16], dest [2:0], signed offset [15:0]. Register 0 is an ordinary writable register.
- R12: `rf_we` and `dmem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | ADDR_W | Instruction word address (the PC) |
| imem_rdata | input | 25 | Instruction word at `imem_addr` |
| rf_raddr_a | output | 3 | Register file read address, regA field |
| rf_raddr_b | output | 3 | Register file read address, regB field |
| rf_rdata_a | input | 32 | Register file read data for port A |
| rf_rdata_b | input | 32 | Register file read data for port B |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write address |
| rf_wdata | output | 32 | Register file write data |
| dmem_re | output | 1 | Data memory read strobe |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | ADDR_W | Data memory word address |
| dmem_wdata | output | 32 | Data memory write data |
| dmem_rdata | input | 32 | Data memory read data |
| halted | output | 1 | Core is in the terminal halt state |
| cycle_count | output | CNT_W | Active-cycle counter |
| retired_count | output | CNT_W | Retired-instruction counter |

## Verification
The bench compares the core with an instruction-level reference model. It compares final registers, memory and exact cycle totals, so a phase skipped or added on any opcode shows up as a wrong cycle count even when the results are right.

Several corner cases are targeted directly. A jalr whose source and destination are the same register would jump to its own link value if the operand were read after the write. A backward beq with a negative offset would run away or never leave the loop if the offset were zero-extended. A write to register 0 would be lost in a design that hard-wires it. Finally, a reset in mid-program and a long wait after halt expose any state that survives reset or keeps counting or writing while halted.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int WORD_W  = 32;
  localparam int INSTR_W = 25;
  localparam int REG_AW  = 3;
  localparam int IMM_W   = 16;
  localparam int OP_LSB  = 22;
  localparam int RA_LSB  = 19;
  localparam int RB_LSB  = 16;
  localparam int DST_LSB = 0;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_NAND = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_JALR = 3'd5,
    OP_HALT = 3'd6,
    OP_NOOP = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_HALT
  } step_e;

  // Sign-extend the offset field of an instruction word.
  function automatic logic [WORD_W-1:0] imm_sext(input logic [INSTR_W-1:0] w);
    return {{(WORD_W-IMM_W){w[IMM_W-1]}}, w[IMM_W-1:0]};
  endfunction

  // Shared ALU: sum, nand, or address generation.
  function automatic logic [WORD_W-1:0] alu_calc(input opcode_e op,
                                                 input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b,
                                                 input logic [WORD_W-1:0] imm);
    case (op)
      OP_NAND:      return ~(a & b);
      OP_LW, OP_SW: return a + imm;
      default:      return a + b;
    endcase
  endfunction

  // Cycles each opcode occupies, from fetch to retirement.
  function automatic logic [3:0] steps_for(input opcode_e op);
    case (op)
      OP_LW:                return 4'd5;
      OP_ADD, OP_NAND, OP_SW: return 4'd4;
      OP_BEQ, OP_JALR:      return 4'd3;
      default:              return 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/mcyc_seq.sv
module mcyc_seq
  import mcyc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e op,
  output logic    fetch_en,
  output logic    decode_en,
  output logic    exec_en,
  output logic    mem_rd,
  output logic    mem_wr,
  output logic    wb_en,
  output logic    retire,
  output logic    halted
);

  step_e      step_q, step_d;
  logic [3:0] in_cnt;

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_FETCH:  step_d = ST_DECODE;
      ST_DECODE: begin
        case (op)
          OP_NOOP: step_d = ST_FETCH;
          OP_HALT: step_d = ST_HALT;
          OP_JALR: step_d = ST_WB;
          default: step_d = ST_EXEC;
        endcase
      end
      ST_EXEC: begin
        case (op)
          OP_LW, OP_SW:   step_d = ST_MEM;
          OP_ADD, OP_NAND: step_d = ST_WB;
          default:        step_d = ST_FETCH;
        endcase
      end
      ST_MEM:  step_d = (op == OP_LW) ? ST_WB : ST_FETCH;
      ST_WB:   step_d = ST_FETCH;
      ST_HALT: step_d = ST_HALT;
      default: step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_FETCH;
    else     step_q <= step_d;
  end

  assign fetch_en  = (step_q == ST_FETCH);
  assign decode_en = (step_q == ST_DECODE);
  assign exec_en   = (step_q == ST_EXEC);
  assign mem_rd    = (step_q == ST_MEM) && (op == OP_LW);
  assign mem_wr    = (step_q == ST_MEM) && (op == OP_SW);
  assign wb_en     = (step_q == ST_WB);
  assign halted    = (step_q == ST_HALT);
  assign retire    = (decode_en && (op == OP_NOOP || op == OP_HALT)) ||
                     (exec_en && op == OP_BEQ) || mem_wr || wb_en;

  // Cycle index inside the current instruction, used only by the checks.
  always_ff @(posedge clk) begin
    if (rst)         in_cnt <= 4'd1;
    else if (retire) in_cnt <= 4'd1;
    else if (!halted) in_cnt <= in_cnt + 4'd1;
  end

  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (rst)
    retire |-> in_cnt == steps_for(op)); // R3
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R9
  AST_LW_READ_BEFORE_WB: assert property (@(posedge clk) disable iff (rst)
    (wb_en && op == OP_LW) |-> $past(mem_rd)); // R4
  AST_RETIRE_REFETCH: assert property (@(posedge clk) disable iff (rst)
    (retire && op != OP_HALT) |=> fetch_en); // R10

endmodule

// File: rtl/mcyc_dpath.sv
module mcyc_dpath
  import mcyc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_en,
  input  logic               decode_en,
  input  logic               exec_en,
  input  logic               mem_rd,
  input  logic               wb_en,
  input  logic [INSTR_W-1:0] imem_rdata,
  input  logic [WORD_W-1:0]  rf_rdata_a,
  input  logic [WORD_W-1:0]  rf_rdata_b,
  input  logic [WORD_W-1:0]  dmem_rdata,
  output opcode_e            op,
  output logic [ADDR_W-1:0]  pc,
  output logic [REG_AW-1:0]  rf_raddr_a,
  output logic [REG_AW-1:0]  rf_raddr_b,
  output logic [REG_AW-1:0]  rf_waddr,
  output logic [WORD_W-1:0]  rf_wdata,
  output logic [ADDR_W-1:0]  dmem_addr,
  output logic [WORD_W-1:0]  dmem_wdata
);

  logic [ADDR_W-1:0]  pc_q;
  logic [INSTR_W-1:0] ir_q;
  logic [WORD_W-1:0]  a_q, b_q, alu_q, mdr_q;
  logic [WORD_W-1:0]  imm;
  logic               operands_eq;

  // Dedicated PC incrementer, kept apart from the shared ALU.
  function automatic logic [ADDR_W-1:0] pc_plus1(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  assign op          = opcode_e'(ir_q[OP_LSB +: 3]);
  assign imm         = imm_sext(ir_q);
  assign operands_eq = (a_q == b_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alu_q <= '0;
      mdr_q <= '0;
    end else begin
      if (fetch_en) begin
        ir_q <= imem_rdata;
        pc_q <= pc_plus1(pc_q);
      end
      if (decode_en) begin
        a_q <= rf_rdata_a;
        b_q <= rf_rdata_b;
      end
      if (exec_en) begin
        alu_q <= alu_calc(op, a_q, b_q, imm);
        if (op == OP_BEQ && operands_eq) pc_q <= pc_q + imm[ADDR_W-1:0];
      end
      if (mem_rd) mdr_q <= dmem_rdata;
      if (wb_en && op == OP_JALR) pc_q <= a_q[ADDR_W-1:0];
    end
  end

  assign pc         = pc_q;
  assign rf_raddr_a = ir_q[RA_LSB +: REG_AW];
  assign rf_raddr_b = ir_q[RB_LSB +: REG_AW];
  assign rf_waddr   = (op == OP_ADD || op == OP_NAND) ? ir_q[DST_LSB +: REG_AW]
                                                      : ir_q[RB_LSB +: REG_AW];
  assign rf_wdata   = (op == OP_LW)   ? mdr_q :
                      (op == OP_JALR) ? WORD_W'(pc_q) : alu_q;
  assign dmem_addr  = alu_q[ADDR_W-1:0];
  assign dmem_wdata = b_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    fetch_en |=> pc_q == $past(pc_q) + 1'b1); // R2
  AST_DECODE_KEEPS_PC: assert property (@(posedge clk) disable iff (rst)
    decode_en |=> $stable(pc_q)); // R8

endmodule

// File: rtl/mcyc_perf.sv
module mcyc_perf #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halted,
  input  logic             retire,
  output logic [CNT_W-1:0] cycle_count,
  output logic [CNT_W-1:0] retired_count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_count   <= '0;
      retired_count <= '0;
    end else begin
      if (!halted) cycle_count <= cycle_count + 1'b1;
      if (retire)  retired_count <= retired_count + 1'b1;
    end
  end

  AST_RETIRED_LE_CYCLES: assert property (@(posedge clk) disable iff (rst)
    retired_count <= cycle_count); // R10
  AST_COUNTS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(cycle_count) && $stable(retired_count)); // R9

endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
  import mcyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  output logic [ADDR_W-1:0]  imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [REG_AW-1:0]  rf_raddr_a,
  output logic [REG_AW-1:0]  rf_raddr_b,
  input  logic [WORD_W-1:0]  rf_rdata_a,
  input  logic [WORD_W-1:0]  rf_rdata_b,
  output logic               rf_we,
  output logic [REG_AW-1:0]  rf_waddr,
  output logic [WORD_W-1:0]  rf_wdata,
  output logic               dmem_re,
  output logic               dmem_we,
  output logic [ADDR_W-1:0]  dmem_addr,
  output logic [WORD_W-1:0]  dmem_wdata,
  input  logic [WORD_W-1:0]  dmem_rdata,
  output logic               halted,
  output logic [CNT_W-1:0]   cycle_count,
  output logic [CNT_W-1:0]   retired_count
);

  opcode_e op;
  logic    fetch_en, decode_en, exec_en, mem_rd, mem_wr, wb_en, retire;

  mcyc_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .fetch_en  (fetch_en),
    .decode_en (decode_en),
    .exec_en   (exec_en),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .wb_en     (wb_en),
    .retire    (retire),
    .halted    (halted)
  );

  mcyc_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .fetch_en   (fetch_en),
    .decode_en  (decode_en),
    .exec_en    (exec_en),
    .mem_rd     (mem_rd),
    .wb_en      (wb_en),
    .imem_rdata (imem_rdata),
    .rf_rdata_a (rf_rdata_a),
    .rf_rdata_b (rf_rdata_b),
    .dmem_rdata (dmem_rdata),
    .op         (op),
    .pc         (imem_addr),
    .rf_raddr_a (rf_raddr_a),
    .rf_raddr_b (rf_raddr_b),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata)
  );

  mcyc_perf #(.CNT_W(CNT_W)) u_perf (
    .clk           (clk),
    .rst           (rst),
    .halted        (halted),
    .retire        (retire),
    .cycle_count   (cycle_count),
    .retired_count (retired_count)
  );

  assign rf_we   = wb_en;
  assign dmem_we = mem_wr;
  assign dmem_re = mem_rd;

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(rf_we && dmem_we)); // R12
  AST_PC_PARKED: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(imem_addr)); // R9

endmodule

// File: tb/test_mcyc_core.sv
`timescale 1ns/1ps
module test_mcyc_core;

  localparam logic [2:0] C_ADD = 3'd0, C_NAND = 3'd1, C_LW = 3'd2, C_SW = 3'd3,
                         C_BEQ = 3'd4, C_JALR = 3'd5, C_HALT = 3'd6, C_NOOP = 3'd7;

  function automatic logic [24:0] enc(input logic [2:0] op, input int ra,
                                      input int rb, input int low);
    return {op, 3'(ra), 3'(rb), 16'(low)};
  endfunction

  // {instruction, expected total cycles of instruction followed by halt}
  localparam logic [32:0] VEC [11] = '{
    {enc(C_ADD,  1, 2, 5),  8'd6},
    {enc(C_NAND, 3, 4, 0),  8'd6},
    {enc(C_LW,   1, 6, 3),  8'd7},
    {enc(C_LW,   7, 2, -5), 8'd7},
    {enc(C_SW,   2, 3, 7),  8'd6},
    {enc(C_BEQ,  2, 2, 5),  8'd5},
    {enc(C_BEQ,  1, 2, 5),  8'd5},
    {enc(C_JALR, 3, 3, 0),  8'd5},
    {enc(C_JALR, 1, 4, 0),  8'd5},
    {enc(C_NOOP, 0, 0, 0),  8'd4},
    {enc(C_HALT, 0, 0, 0),  8'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr;
  logic [24:0] imem_rdata;
  logic [2:0]  rf_raddr_a, rf_raddr_b, rf_waddr;
  logic [31:0] rf_rdata_a, rf_rdata_b, rf_wdata, dmem_wdata, dmem_rdata;
  logic        rf_we, dmem_re, dmem_we, halted;
  logic [15:0] dmem_addr;
  logic [31:0] cycle_count, retired_count;

  logic [24:0] imem [64];
  logic [31:0] rf [8];
  logic [31:0] dmem [64];
  logic [31:0] ref_rf [8];
  logic [31:0] ref_dm [64];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mcyc_core i_mcyc_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
    .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .dmem_re(dmem_re), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .halted(halted),
    .cycle_count(cycle_count), .retired_count(retired_count)
  );

  assign imem_rdata = imem[imem_addr[5:0]];
  assign rf_rdata_a = rf[rf_raddr_a];
  assign rf_rdata_b = rf[rf_raddr_b];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  always @(posedge clk) begin
    if (rf_we)   rf[rf_waddr] <= rf_wdata;
    if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      C_ADD, C_NAND: return "R3";
      C_LW:          return "R4";
      C_SW:          return "R5";
      C_BEQ:         return "R6";
      C_JALR:        return "R7";
      C_NOOP:        return "R8";
      default:       return "R9";
    endcase
  endfunction

  // Instruction-level reference model; cycle costs per opcode from R3-R9.
  task automatic run_ref(output int cyc, output int ret, output int lwn);
    logic [15:0] pc = '0;
    cyc = 0; ret = 0; lwn = 0;
    for (int s = 0; s < 1000; s++) begin
      logic [24:0] w = imem[pc[5:0]];
      logic [2:0]  op = w[24:22];
      int          ra = int'(w[21:19]);
      int          rb = int'(w[18:16]);
      int          rd = int'(w[2:0]);
      logic [31:0] off = {{16{w[15]}}, w[15:0]};
      logic [31:0] tgt;
      logic [15:0] nxt = pc + 16'd1;
      ret++;
      case (op)
        C_ADD:  begin ref_rf[rd] = ref_rf[ra] + ref_rf[rb]; cyc += 4; end
        C_NAND: begin ref_rf[rd] = ~(ref_rf[ra] & ref_rf[rb]); cyc += 4; end
        C_LW:   begin
          tgt = ref_rf[ra] + off; ref_rf[rb] = ref_dm[tgt[5:0]]; cyc += 5; lwn++;
        end
        C_SW:   begin tgt = ref_rf[ra] + off; ref_dm[tgt[5:0]] = ref_rf[rb]; cyc += 4; end
        C_BEQ:  begin
          if (ref_rf[ra] == ref_rf[rb]) nxt = nxt + off[15:0];
          cyc += 3;
        end
        C_JALR: begin
          tgt = ref_rf[ra]; ref_rf[rb] = 32'(nxt); nxt = tgt[15:0]; cyc += 3;
        end
        C_NOOP: cyc += 2;
        default: begin cyc += 2; break; end
      endcase
      pc = nxt;
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic copy_ref();
    for (int i = 0; i < 8; i++)  ref_rf[i] = rf[i];
    for (int i = 0; i < 64; i++) ref_dm[i] = dmem[i];
  endtask

  task automatic run_and_compare(input string req, input int exp_cycles);
    int n = 0;
    int lw_seen = 0;
    int both = 0;
    int r_cyc, r_ret, r_lw;
    logic [31:0] snap [8];
    logic [31:0] cyc_snap;
    logic [15:0] pc_snap;
    run_ref(r_cyc, r_ret, r_lw);
    rst = 1'b0;
    chk("R1", "pc after reset", 32'(imem_addr), 32'd0);
    chk("R1", "cycles after reset", cycle_count, 32'd0);
    while (!halted && n < 2000) begin
      if (dmem_re) lw_seen++;
      if (rf_we && dmem_we) both++;
      @(negedge clk);
      n++;
    end
    chk("R9", "reached halt", 32'(halted), 32'd1);
    chk(req, "cycle total", cycle_count, 32'(exp_cycles));
    chk("R10", "cycles vs model", cycle_count, 32'(r_cyc));
    chk("R10", "retired", retired_count, 32'(r_ret));
    chk("R4", "lw read strobes", 32'(lw_seen), 32'(r_lw));
    chk("R12", "simultaneous writes", 32'(both), 32'd0);
    for (int i = 0; i < 8; i++) chk(req, $sformatf("reg %0d", i), rf[i], ref_rf[i]);
    for (int i = 0; i < 64; i++)
      if (dmem[i] !== ref_dm[i]) chk(req, $sformatf("mem %0d", i), dmem[i], ref_dm[i]);
    for (int i = 0; i < 8; i++) snap[i] = rf[i];
    cyc_snap = cycle_count;
    pc_snap  = imem_addr;
    repeat (5) @(negedge clk);
    chk("R9", "cycles frozen", cycle_count, cyc_snap);
    chk("R9", "pc parked", 32'(imem_addr), 32'(pc_snap));
    for (int i = 0; i < 8; i++) chk("R9", "regs frozen", rf[i], snap[i]);
  endtask

  task automatic load_directed();
    for (int i = 0; i < 64; i++) begin imem[i] = enc(C_HALT, 0, 0, 0); dmem[i] = '0; end
    for (int i = 0; i < 8; i++) rf[i] = '0;
    dmem[10] = 32'd3; dmem[11] = 32'd1; dmem[12] = 32'd12;
    imem[0]  = enc(C_LW,   0, 1, 10);
    imem[1]  = enc(C_LW,   0, 2, 11);
    imem[2]  = enc(C_NAND, 2, 2, 3);
    imem[3]  = enc(C_ADD,  3, 2, 3);
    imem[4]  = enc(C_ADD,  1, 3, 1);
    imem[5]  = enc(C_SW,   1, 1, 20);
    imem[6]  = enc(C_BEQ,  1, 0, 2);
    imem[7]  = enc(C_BEQ,  0, 0, -4);   // backward branch, R6 / R11
    imem[8]  = enc(C_NOOP, 0, 0, 0);
    imem[9]  = enc(C_LW,   0, 4, 12);
    imem[10] = enc(C_JALR, 4, 5, 0);
    imem[11] = enc(C_HALT, 0, 0, 0);
    imem[12] = enc(C_NOOP, 0, 0, 0);
    imem[13] = enc(C_ADD,  5, 5, 0);    // writes register 0, R11
    imem[14] = enc(C_HALT, 0, 0, 0);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int dir_cyc, dir_ret, dir_lw;
    // Vector table: one instruction followed by halt.
    foreach (VEC[k]) begin
      hold_reset();
      for (int i = 0; i < 64; i++) begin
        imem[i] = enc(C_HALT, 0, 0, 0);
        dmem[i] = 32'(i * 7 + 100);
      end
      for (int i = 0; i < 8; i++) rf[i] = 32'(4 * i + 1);
      imem[0] = VEC[k][32:8];
      copy_ref();
      if (k == 0) begin
        rst = 1'b0;
        chk("R1", "halted low after reset", 32'(halted), 32'd0);
        chk("R1", "retired after reset", retired_count, 32'd0);
        @(negedge clk);
        chk("R2", "pc after fetch", 32'(imem_addr), 32'd1);
        hold_reset();
      end
      run_and_compare(req_of(VEC[k][32:30]), int'(VEC[k][7:0]));
    end

    // Directed loop program with lw, sw, backward beq, jalr, r0 write.
    hold_reset();
    load_directed();
    copy_ref();
    run_ref(dir_cyc, dir_ret, dir_lw);
    chk("R11", "model r0 written", ref_rf[0], 32'd22);
    hold_reset();
    load_directed();
    copy_ref();
    run_and_compare("R11", dir_cyc);

    // Reset in the middle of the program.
    hold_reset();
    load_directed();
    copy_ref();
    rst = 1'b0;
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "pc after mid reset", 32'(imem_addr), 32'd0);
    chk("R1", "cycles after mid reset", cycle_count, 32'd0);
    chk("R1", "retired after mid reset", retired_count, 32'd0);
    chk("R1", "halted after mid reset", 32'(halted), 32'd0);
    run_and_compare("R1", dir_cyc);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule